// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Peripheral Override

The block is an eight-pin general-purpose I/O port. Software sees a direction register, an output latch register, a read-only pin register and a control register that holds one global pull-up disable bit. Each pin drives three pad-side signals: output value, output enable and pull-up enable. Each pin also takes one pad input. The port offers the digital input to peripherals in two forms: raw, and through a synchronizer for software reads.

Each peripheral that borrows a pin gets a set of enable/value override pairs for that pin. The pairs cover the pull-up, the output driver enable, the driven value and the digital input enable. A peripheral can also pulse a toggle line that inverts the pin's latch bit. With every override enable low, the pin behaves purely from the registers and the sleep-state input.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, latch and control registers read 0, and every pin has output enable 0 and pull-up 0 when no override is active.
- R2: The bus address selects the register: 0 is direction, 1 is latch, 2 is the pin register, 3 is control. Reads are combinational. Writes to address 2 change nothing. Only control bit 4 (pull-up disable) is stored, and the other control bits read 0.
- R3: With the pull-up override enable low, the pull-up is on exactly when the direction bit is 0, the latch bit is 1 and the pull-up disable bit is 0.
- R4: With the pull-up override enable high, the pull-up equals the pull-up override value, whatever the direction, latch and disable bits are.
- R5: The output enable equals the driver override value when the driver override enable is high. Otherwise it equals the direction bit.
- R6: When the output enable is high, the pad output is the value override value if the value override enable is high, and the latch bit if it is low. When the output enable is low, the pad output is 0.
- R7: The digital input enable equals the input override value when the input override enable is high. Otherwise it is 1 when the sleep input is 0 and 0 when the sleep input is 1. The raw input is the pad input ANDed with that enable, with no register in the path.
- R8: The pin register returns the raw input of R7 after two flip-flops, so a change becomes readable after two rising edges. A disabled input reads 0.
- R9: A rising edge on a pin's toggle line inverts that pin's latch bit once. A toggle line held high for several cycles inverts it only once.
- R10: A bus write to the latch in the same cycle as a toggle edge takes priority: the latch takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sleep_i | input | 1 | High while the system sleeps |
| pu_ovr_en | input | 8 | Per-pin pull-up override enable |
| pu_ovr_val | input | 8 | Per-pin pull-up override value |
| oe_ovr_en | input | 8 | Per-pin output-enable override enable |
| oe_ovr_val | input | 8 | Per-pin output-enable override value |
| dv_ovr_en | input | 8 | Per-pin driven-value override enable |
| dv_ovr_val | input | 8 | Per-pin driven-value override value |
| tgl_ovr | input | 8 | Per-pin latch toggle request (rising edge) |
| ie_ovr_en | input | 8 | Per-pin input-enable override enable |
| ie_ovr_val | input | 8 | Per-pin input-enable override value |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output driver enable |
| pad_pu | output | 8 | Pad pull-up enable |
| in_raw | output | 8 | Unsynchronized gated input for peripherals |

## Verification
The bench sweeps every combination of direction, latch, pull-up disable, sleep, pad level and all eight override bits, spread across the pins. A design that folded the pull-up disable into the override path, or let the latch drive an undriven pad, would show a wrong pull-up or pad value in some combination. The sweep also reads the pin register only after the synchronizer has settled, so a wrong gate or a missing stage shows as a wrong read. Separate cases show a toggle line held high inverting the latch only once, a toggle that coincides with a latch write losing to the write, writes to the pin register having no effect, and the unused control bits reading 0.

// File: rtl/gpio_pkg.sv
// Shared constants for the general-purpose I/O port.
// Assumes a bus of at least PUD_BIT+1 bits.
package gpio_pkg;
    localparam int PORT_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int PUD_BIT  = 4;
    localparam int SYNC_LEN = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR   = 2'd0,
        REG_LATCH = 2'd1,
        REG_PIN   = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
// Register file: direction, output latch with toggle edge detect, control.
// Assumes a synchronous active-low reset and a single write port.
// A latch write in the same cycle as a toggle edge wins.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      tgl,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      latch_q,
    output logic              pud_q
);
    logic [W-1:0] tgl_prev;
    logic [W-1:0] tgl_rise;
    logic         wr_dir;
    logic         wr_latch;
    logic         wr_ctrl;

    // Decode the write strobes per register.
    always_comb begin
        wr_dir   = we && (addr == REG_DIR);
        wr_latch = we && (addr == REG_LATCH);
        wr_ctrl  = we && (addr == REG_CTRL);
        tgl_rise = tgl & ~tgl_prev;
    end

    // Remember the toggle lines to find their rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_prev <= '0;
        else        tgl_prev <= tgl;
    end

    // Direction register.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output latch: a bus write first, otherwise toggle on an edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (wr_latch) latch_q <= wdata;
        else               latch_q <= latch_q ^ tgl_rise;
    end

    // Control register: only the pull-up disable bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       pud_q <= 1'b0;
        else if (wr_ctrl) pud_q <= wdata[PUD_BIT];
    end

    // R10
    latch_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_latch |=> latch_q == $past(wdata));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_latch && tgl == '0) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin override selection for pull-up, driver, value and input enable.
// Pure combinational logic; one instance per pin.
module gpio_pin_mux (
    input  logic dir_b,
    input  logic latch_b,
    input  logic pud,
    input  logic sleep,
    input  logic pu_en,
    input  logic pu_val,
    input  logic oe_en,
    input  logic oe_val,
    input  logic dv_en,
    input  logic dv_val,
    input  logic ie_en,
    input  logic ie_val,
    input  logic pad_lvl,
    output logic pu_o,
    output logic oe_o,
    output logic out_o,
    output logic ie_o,
    output logic raw_o
);
    logic drive_val;

    // Resolve each pin attribute from its override pair or the registers.
    always_comb begin
        pu_o      = pu_en ? pu_val : (~dir_b & latch_b & ~pud);
        oe_o      = oe_en ? oe_val : dir_b;
        drive_val = dv_en ? dv_val : latch_b;
        out_o     = oe_o & drive_val;
        ie_o      = ie_en ? ie_val : ~sleep;
        raw_o     = pad_lvl & ie_o;
    end
endmodule

// File: rtl/gpio_sync.sv
// Multi-stage flip-flop synchronizer for a vector of pad inputs.
// Assumes a synchronous active-low reset; the stages clear to 0.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= d;
                end
            end else begin : g_next
                // Later stages pass the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
// Top of the general-purpose I/O port: registers, per-pin override
// muxes, the input synchronizer and the read-back multiplexer.
// Assumes bus accesses are single-cycle and reads are combinational.
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic              sleep_i,
    input  logic [PORT_W-1:0] pu_ovr_en,
    input  logic [PORT_W-1:0] pu_ovr_val,
    input  logic [PORT_W-1:0] oe_ovr_en,
    input  logic [PORT_W-1:0] oe_ovr_val,
    input  logic [PORT_W-1:0] dv_ovr_en,
    input  logic [PORT_W-1:0] dv_ovr_val,
    input  logic [PORT_W-1:0] tgl_ovr,
    input  logic [PORT_W-1:0] ie_ovr_en,
    input  logic [PORT_W-1:0] ie_ovr_val,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_pu,
    output logic [PORT_W-1:0] in_raw
);
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] latch_q;
    logic              pud_q;
    logic [PORT_W-1:0] in_en;
    logic [PORT_W-1:0] pin_q;
    logic [1:0]        warm;

    gpio_regs #(.W(PORT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .tgl     (tgl_ovr),
        .dir_q   (dir_q),
        .latch_q (latch_q),
        .pud_q   (pud_q)
    );

    genvar i;
    generate
        for (i = 0; i < PORT_W; i++) begin : g_pin
            gpio_pin_mux u_mux (
                .dir_b   (dir_q[i]),
                .latch_b (latch_q[i]),
                .pud     (pud_q),
                .sleep   (sleep_i),
                .pu_en   (pu_ovr_en[i]),
                .pu_val  (pu_ovr_val[i]),
                .oe_en   (oe_ovr_en[i]),
                .oe_val  (oe_ovr_val[i]),
                .dv_en   (dv_ovr_en[i]),
                .dv_val  (dv_ovr_val[i]),
                .ie_en   (ie_ovr_en[i]),
                .ie_val  (ie_ovr_val[i]),
                .pad_lvl (pad_in[i]),
                .pu_o    (pad_pu[i]),
                .oe_o    (pad_oe[i]),
                .out_o   (pad_out[i]),
                .ie_o    (in_en[i]),
                .raw_o   (in_raw[i])
            );
        end
    endgenerate

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_raw),
        .q     (pin_q)
    );

    // Select the register addressed by the bus for reading.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DIR:   bus_rdata = dir_q;
            REG_LATCH: bus_rdata = latch_q;
            REG_PIN:   bus_rdata = pin_q;
            REG_CTRL:  bus_rdata[PUD_BIT] = pud_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Count cycles since reset so history-based checks start late enough.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    // R8
    pin_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> pin_q == $past(in_raw, 2));

    // R7
    raw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_raw & ~in_en) == '0);

    // R3
    pud_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pud_q && pu_ovr_en == '0) |-> pad_pu == '0);

    // R6
    idle_pad_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sleep_i = 1'b0;
    logic [7:0] pu_ovr_en = '0, pu_ovr_val = '0, oe_ovr_en = '0, oe_ovr_val = '0;
    logic [7:0] dv_ovr_en = '0, dv_ovr_val = '0, tgl_ovr = '0;
    logic [7:0] ie_ovr_en = '0, ie_ovr_val = '0, pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu, in_raw;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_i(sleep_i),
        .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
        .oe_ovr_en(oe_ovr_en), .oe_ovr_val(oe_ovr_val),
        .dv_ovr_en(dv_ovr_en), .dv_ovr_val(dv_ovr_val), .tgl_ovr(tgl_ovr),
        .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .in_raw(in_raw)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] e_dir, e_lat, e_pu, e_oe, e_out, e_raw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); chk("R1 dir", r, 8'h00);
        rd(2'd1, r); chk("R1 latch", r, 8'h00);
        rd(2'd3, r); chk("R1 ctrl", r, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_pu", pad_pu, 8'h00);

        // R2 register map, masking and read-only pin register
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        wr(2'd2, 8'hFF);
        rd(2'd0, r); chk("R2 dir after pin write", r, 8'hA5);
        rd(2'd1, r); chk("R2 latch after pin write", r, 8'h3C);
        wr(2'd3, 8'hFF);
        rd(2'd3, r); chk("R2 ctrl mask", r, 8'h10);
        wr(2'd3, 8'hEF);
        rd(2'd3, r); chk("R2 ctrl clear", r, 8'h00);

        // R9 single pulse, then held toggle line
        wr(2'd1, 8'h0F);
        @(negedge clk); tgl_ovr = 8'h33;
        @(negedge clk); tgl_ovr = 8'h00;
        rd(2'd1, r); chk("R9 pulse", r, 8'h3C);
        @(negedge clk); tgl_ovr = 8'hC1;
        repeat (4) @(negedge clk);
        rd(2'd1, r); chk("R9 held", r, 8'hFD);
        @(negedge clk); tgl_ovr = 8'h00;
        rd(2'd1, r); chk("R9 release", r, 8'hFD);

        // R10 write takes priority over a coincident toggle edge
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h5A; tgl_ovr = 8'hFF;
        @(negedge clk);
        bus_we = 1'b0; tgl_ovr = 8'h00;
        rd(2'd1, r); chk("R10 write wins", r, 8'h5A);

        // R3..R8 sweep over every per-pin and global input combination
        for (int c = 0; c < 8192; c++) begin
            logic pud, slp;
            pud = c[12]; slp = c[11];
            for (int i = 0; i < 8; i++) begin
                logic [10:0] v;
                logic ie;
                v = 11'((c + i * 397) & 2047);
                e_dir[i] = v[0]; e_lat[i] = v[1];
                pu_ovr_en[i] = v[2]; pu_ovr_val[i] = v[3];
                oe_ovr_en[i] = v[4]; oe_ovr_val[i] = v[5];
                dv_ovr_en[i] = v[6]; dv_ovr_val[i] = v[7];
                ie_ovr_en[i] = v[8]; ie_ovr_val[i] = v[9];
                pad_in[i] = v[10];
                e_pu[i]  = v[2] ? v[3] : (~v[0] & v[1] & ~pud);
                e_oe[i]  = v[4] ? v[5] : v[0];
                e_out[i] = e_oe[i] & (v[6] ? v[7] : v[1]);
                ie       = v[8] ? v[9] : ~slp;
                e_raw[i] = v[10] & ie;
            end
            sleep_i = slp;
            wr(2'd0, e_dir);
            wr(2'd1, e_lat);
            wr(2'd3, {3'b101, pud, 4'b0110});
            repeat (3) @(negedge clk);
            bus_addr = 2'd2;
            #1;
            if (c[1:0] == 2'b00 || pu_ovr_en != 8'hFF)
                chk(pud ? "R3 pull-up disabled" : "R3 R4 pull-up", pad_pu, e_pu);
            else
                chk("R4 pull-up override", pad_pu, e_pu);
            chk("R5 output enable", pad_oe, e_oe);
            chk("R6 pad value", pad_out, e_out);
            chk("R7 raw input", in_raw, e_raw);
            chk("R8 pin read", bus_rdata, e_raw);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule